// File: doc/BRIEF.md
# Staged Configuration Load Controller

This block takes a stream of words from a narrow load port and turns it into writes to the configuration storage of a video pipeline. A falling edge on the load strobe announces that the next accepted word is a target address. The address range picks a group size (one, two, four or ten words), and the data words that follow are gathered in a staging buffer. The target bank sees nothing until the whole group has arrived. At that point one strobe carries the target address and the full group to the register banks.

Three addresses select gamma lookup tables. For these, the words are not staged. Each word goes straight out on a table write port with an index that counts up from zero, and a done flag marks the final entry. An address outside every defined range turns the port deaf until the next strobe edge. A strobe edge in the middle of a group drops the partial group.

Top module: `cfg_load_ctrl`

## Requirements
- R1: After reset, `commit`, `lut_we` and `lut_done` are low and `commit_data` is all zero.
- R2: The load strobe `ld` has a falling edge when it is sampled high on one rising clock edge and low on the next. The first word with `din_vld` high, taken on that edge or on any later one, is the address. Words seen while no address is pending and no group is open are discarded.
- R3: Addresses 0x0000 to 0x0003 take ten data words. The k-th data word, counting from 0, lands in `commit_data[k*DW +: DW]`, so the key-scale value is in slot 9.
- R4: Addresses 0x0200 to 0x020A, and addresses with high byte 0x06 to 0x0B and low byte 0x00 to 0x03, take one data word each.
- R5: Addresses 0x0C00 and 0x0D00 take two data words each.
- R6: Addresses with high byte 0x0E to 0x13 and low byte 0x00 to 0x03 take four data words. Slots above the group size read as zero on commit.
- R7: `commit` is high for exactly one cycle, the cycle after the final word of a group is accepted, with `commit_addr` equal to the address. `commit_data` changes only with a commit.
- R8: Any other address produces neither a commit nor a table write. The words that follow it are discarded until the next falling edge.
- R9: A falling edge of `ld` before a group is complete abandons that group without a commit. The next group starts with empty slots.
- R10: Addresses 0x0300, 0x0400 and 0x0500 select table 0, 1 and 2 on `lut_sel`. Each data word appears on `lut_data` with `lut_we` high in the cycle after it is accepted. `lut_idx` runs 0, 1, 2 and so on, and no commit is raised.
- R11: `lut_done` is high together with the write of index LUT_N-1. Later words are ignored until the next falling edge.
- R12: Once a group has committed, further words produce no commit and leave `commit_data` unchanged until the next falling edge.
- R13: A cycle with `din_vld` low is not counted as a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld | input | 1 | Load strobe; a falling edge marks the next word as an address |
| din_vld | input | 1 | Qualifies `din` in this cycle |
| din | input | DW | Address or data word |
| commit | output | 1 | One-cycle group write strobe |
| commit_addr | output | DW | Target address of the committed group |
| commit_data | output | 10*DW | Group words, slot k at bits k*DW upward |
| lut_we | output | 1 | Table entry write |
| lut_sel | output | 2 | Table being written (0, 1, 2) |
| lut_idx | output | $clog2(LUT_N) | Table entry index |
| lut_data | output | DW | Table entry value |
| lut_done | output | 1 | High with the write of the last table entry |

## Verification
The bench uses the default parameters: a 16-bit word and a full table length of 1024. This means a complete table load is streamed and the done flag is seen on index 1023. The table from every group size also passes through ten-slot packing, including the slots that must stay zero. Addresses just outside each range are included. Those edge values, such as 0x020B and 0x0604, only show their effect with the full 16-bit address word.

// File: rtl/cfg_load_ctrl.sv
`timescale 1ns/1ps
module cfg_load_ctrl #(
  parameter int DW = 16,
  parameter int LUT_N = 1024,
  localparam int GRP_MAX = 10,
  localparam int IW = $clog2(LUT_N)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ld,
  input  logic                  din_vld,
  input  logic [DW-1:0]         din,
  output logic                  commit,
  output logic [DW-1:0]         commit_addr,
  output logic [GRP_MAX*DW-1:0] commit_data,
  output logic                  lut_we,
  output logic [1:0]            lut_sel,
  output logic [IW-1:0]         lut_idx,
  output logic [DW-1:0]         lut_data,
  output logic                  lut_done
);
  localparam int CW = $clog2(LUT_N + 1);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_GRP, S_LUT} st_t;

  st_t st;
  logic ld_q;
  logic [CW-1:0] cnt, need;
  logic [DW-1:0] addr_q;
  logic [1:0] tsel;
  logic [GRP_MAX-1:0][DW-1:0] stage, grp_next;

  wire fall = ld_q & ~ld;
  wire addr_phase = fall || st == S_ADDR;
  wire [DW-1:0] hi = din >> 8;
  wire [DW-1:0] lo = din & DW'(8'hFF);

  logic [CW-1:0] dec_n;
  logic dec_lut;
  always_comb begin
    dec_n = '0;
    dec_lut = 1'b0;
    if (hi == 0 && lo <= 3) dec_n = CW'(10);
    else if (hi == 2 && lo <= 8'h0A) dec_n = CW'(1);
    else if (lo == 0 && hi >= 3 && hi <= 5) dec_lut = 1'b1;
    else if (hi >= 6 && hi <= 8'h0B && lo <= 3) dec_n = CW'(1);
    else if (lo == 0 && (hi == 8'h0C || hi == 8'h0D)) dec_n = CW'(2);
    else if (hi >= 8'h0E && hi <= 8'h13 && lo <= 3) dec_n = CW'(4);
  end

  always_comb begin
    for (int i = 0; i < GRP_MAX; i++)
      grp_next[i] = (cnt == CW'(i)) ? din : stage[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ld_q <= 1'b1;
      cnt <= '0;
      need <= '0;
      addr_q <= '0;
      tsel <= '0;
      stage <= '0;
      commit <= 1'b0;
      commit_addr <= '0;
      commit_data <= '0;
      lut_we <= 1'b0;
      lut_sel <= '0;
      lut_idx <= '0;
      lut_data <= '0;
      lut_done <= 1'b0;
    end else begin
      ld_q <= ld;
      commit <= 1'b0;
      lut_we <= 1'b0;
      lut_done <= 1'b0;
      if (din_vld && addr_phase) begin
        cnt <= '0;
        addr_q <= din;
        stage <= '0;
        need <= dec_n;
        tsel <= hi[1:0] + 2'd1;
        if (dec_lut) st <= S_LUT;
        else if (dec_n != 0) st <= S_GRP;
        else st <= S_IDLE;
      end else if (fall) begin
        st <= S_ADDR;
      end else if (din_vld && st == S_GRP) begin
        stage <= grp_next;
        cnt <= cnt + 1'b1;
        if (cnt + 1'b1 == need) begin
          commit <= 1'b1;
          commit_addr <= addr_q;
          commit_data <= grp_next;
          st <= S_IDLE;
        end
      end else if (din_vld && st == S_LUT) begin
        lut_we <= 1'b1;
        lut_sel <= tsel;
        lut_idx <= cnt[IW-1:0];
        lut_data <= din;
        cnt <= cnt + 1'b1;
        if (cnt == CW'(LUT_N - 1)) begin
          lut_done <= 1'b1;
          st <= S_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_load_ctrl_chk.sv
`timescale 1ns/1ps
module cfg_load_ctrl_chk #(
  parameter int DW = 16,
  parameter int LUT_N = 1024,
  localparam int GRP_MAX = 10,
  localparam int IW = $clog2(LUT_N)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ld,
  input logic                  din_vld,
  input logic [DW-1:0]         din,
  input logic                  commit,
  input logic [DW-1:0]         commit_addr,
  input logic [GRP_MAX*DW-1:0] commit_data,
  input logic                  lut_we,
  input logic [1:0]            lut_sel,
  input logic [IW-1:0]         lut_idx,
  input logic [DW-1:0]         lut_data,
  input logic                  lut_done
);
  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n) commit |=> !commit); // R7
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !commit |-> $stable(commit_data)); // R7
  AST_NO_MIXED_WRITE: assert property (@(posedge clk) disable iff (!rst_n) commit |-> !lut_we); // R10
  AST_TABLE_SEL: assert property (@(posedge clk) disable iff (!rst_n) lut_we |-> lut_sel != 2'd3); // R10
  AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n) lut_done |-> (lut_we && lut_idx == IW'(LUT_N - 1))); // R11
  AST_ABORT_EDGE: assert property (@(posedge clk) disable iff (!rst_n) $fell(ld) |=> !commit); // R9
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n) commit |-> (commit_addr >> 8) <= DW'(8'h13)); // R8
endmodule

bind cfg_load_ctrl cfg_load_ctrl_chk #(.DW(DW), .LUT_N(LUT_N)) u_chk (.*);

// File: tb/cfg_load_ctrl_test.sv
`timescale 1ns/1ps
module cfg_load_ctrl_test;
  localparam int DW = 16;
  localparam int LUT_N = 1024;
  localparam int IW = $clog2(LUT_N);
  localparam int NV = 15;
  localparam logic [31:0] VEC [NV] = '{
    32'h0000_000A, 32'h0003_000A, 32'h0200_0001, 32'h020A_0001, 32'h0600_0001,
    32'h0B03_0001, 32'h0C00_0002, 32'h0D00_0002, 32'h0E00_0004, 32'h1303_0004,
    32'h020B_0000, 32'h0604_0000, 32'h1400_0000, 32'h0301_0000, 32'h0C01_0000};

  logic clk = 0, rst_n = 0, ld = 1, din_vld = 0;
  logic [DW-1:0] din = '0;
  logic commit, lut_we, lut_done;
  logic [DW-1:0] commit_addr, lut_data;
  logic [10*DW-1:0] commit_data;
  logic [1:0] lut_sel;
  logic [IW-1:0] lut_idx;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  cfg_load_ctrl #(.DW(DW), .LUT_N(LUT_N)) uut (
    .clk(clk), .rst_n(rst_n), .ld(ld), .din_vld(din_vld), .din(din),
    .commit(commit), .commit_addr(commit_addr), .commit_data(commit_data),
    .lut_we(lut_we), .lut_sel(lut_sel), .lut_idx(lut_idx), .lut_data(lut_data),
    .lut_done(lut_done));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [DW-1:0] w);
    din = w; din_vld = 1; @(negedge clk); din_vld = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe();
    ld = 1; @(negedge clk); ld = 0;
  endtask

  task automatic slot_chk(input int s, input logic [DW-1:0] exp, input string req);
    chk(commit_data[s*DW +: DW] == exp, req, 32'(commit_data[s*DW +: DW]), 32'(exp));
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(2);
    chk(commit == 0 && lut_we == 0 && lut_done == 0, "R1 strobes", {commit, lut_we, lut_done}, 0);
    chk(commit_data == '0, "R1 data", 32'(commit_data), 0);
    rst_n = 1;
    idle(1);

    for (int v = 0; v < NV; v++) begin
      automatic logic [15:0] a = VEC[v][31:16];
      automatic int n = int'(VEC[v][15:0]);
      automatic string req = n == 10 ? "R3" : n == 1 ? "R4" : n == 2 ? "R5" : n == 4 ? "R6" : "R8";
      strobe();
      put(a);
      if (n == 0) begin
        for (int k = 0; k < 3; k++) begin
          put(16'hEE00 + 16'(k));
          chk(!commit && !lut_we, "R8", {commit, lut_we}, 0);
        end
      end else begin
        for (int i = 0; i < n; i++) begin
          put(16'(v * 256 + i + 16'h1000));
          if (i < n - 1) chk(!commit, "R7 early", commit, 0);
          else begin
            chk(commit, "R7 strobe", commit, 1);
            chk(commit_addr == a, req, commit_addr, a);
            for (int s = 0; s < 10; s++)
              slot_chk(s, s < n ? 16'(v * 256 + s + 16'h1000) : 16'h0, req);
          end
        end
        idle(1);
        chk(!commit, "R7 one cycle", commit, 0);
      end
    end

    // R13: gaps inside a four-word group
    strobe(); put(16'h0F02);
    for (int i = 0; i < 4; i++) begin
      idle(2);
      chk(!commit, "R13 gap", commit, 0);
      put(16'h2200 + 16'(i));
    end
    chk(commit && commit_addr == 16'h0F02, "R13", {commit, commit_addr}, {1'b1, 16'h0F02});

    // R12: extra words after a commit
    put(16'h7777); put(16'h7778);
    chk(!commit, "R12 no commit", commit, 0);
    slot_chk(0, 16'h2200, "R12 data held");

    // R9: abort a partial group, then a fresh single-word group
    strobe(); put(16'h0E01); put(16'h3300); put(16'h3301);
    strobe(); put(16'h0201);
    chk(!commit, "R9 no commit on abort", commit, 0);
    put(16'h4400);
    chk(commit && commit_addr == 16'h0201, "R9 new group", commit_addr, 16'h0201);
    slot_chk(0, 16'h4400, "R9");
    slot_chk(1, 16'h0000, "R9 empty slot");

    // R2: address arrives some cycles after the edge; words before the edge ignored
    ld = 1; put(16'h0200); put(16'h5555);
    chk(!commit, "R2 no edge", commit, 0);
    ld = 0; idle(3);
    put(16'h0C00); put(16'h6600); put(16'h6601);
    chk(commit && commit_addr == 16'h0C00, "R2 late address", commit_addr, 16'h0C00);

    // R10/R11: full table load on table 1
    strobe(); put(16'h0400);
    for (int i = 0; i < LUT_N; i++) begin
      automatic logic [DW-1:0] w = 16'(i) ^ 16'h5A5A;
      put(w);
      chk(lut_we && lut_idx == IW'(i) && lut_data == w && lut_sel == 2'd1 && !commit,
          "R10", {lut_we, 6'(lut_sel), IW'(lut_idx)}, {1'b1, 6'd1, IW'(i)});
      chk(lut_done == (i == LUT_N - 1), "R11 done", lut_done, 32'(i == LUT_N - 1));
    end
    put(16'h1234);
    chk(!lut_we && !lut_done, "R11 ignored after last", {lut_we, lut_done}, 0);

    // R10/R9: table abort, then restart on table 0
    strobe(); put(16'h0500); put(16'h0001); put(16'h0002);
    chk(lut_sel == 2'd2 && lut_idx == 1, "R10 sel2", {lut_sel, lut_idx}, {2'd2, IW'(1)});
    strobe(); put(16'h0300); put(16'hABCD);
    chk(lut_we && lut_sel == 2'd0 && lut_idx == 0 && lut_data == 16'hABCD, "R10 restart",
        {lut_sel, lut_idx}, 0);

    idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule